// File: doc/BRIEF.md
# Programmable Video Sync Timing Generator

This block produces the vertical sync, horizontal sync and data-enable strobes of a video raster, plus a one-cycle frame marker, from a single pixel clock. Every edge is placed by its own pixel-count value. No line or column counter is compared against porch widths. Vertical sync is timed entirely in pixel clocks: an initial delay, then a high count and a low count that repeat. The sum of the high and low counts is the frame period.

Horizontal sync and data enable each run an independent sequence that restarts at every frame. Each sequence has a delay measured from the vertical sync rising edge, then alternating high and low counts, for a programmed number of high pulses. When the pulses are used up, or when the next frame starts, the sequence stops. A host loads the configuration inputs in parallel. The block copies them into shadow registers only at a frame start or while it is disabled. A new raster therefore never tears a frame that is in progress.

The vertical machine has four states. IDLE goes to DELAY on enable, or straight to HIGH when the delay is zero. DELAY goes to HIGH when its count runs out. HIGH goes to LOW and LOW goes back to HIGH, each when its count runs out. Each strobe machine also has four states. IDLE goes on a frame start to WAIT, to HIGH when the delay is zero, or stays in IDLE when the repeat count is zero. WAIT goes to HIGH. HIGH goes to LOW, or to IDLE after the last pulse. LOW goes back to HIGH. A frame start takes any strobe machine out of any state, and a low enable returns every machine to IDLE.

Top module: `sync_timing_gen`

## Requirements
- R1: While reset is asserted, and from the first clock edge at which enable is sampled low, vs, hs, de and frame_start are all 0.
- R2: After the clock edge that first samples enable high, vs rises exactly cfg_vs_dly cycles later. With cfg_vs_dly = 0 it is high right after that edge. The delay applies only once per enable.
- R3: vs stays high for cfg_vs_high cycles and low for cfg_vs_low cycles, and this repeats. A count of 0 acts as 1.
- R4: frame_start is high for exactly one cycle, the first cycle of every vs high period, and at no other time.
- R5: hs first rises cfg_hs_dly cycles after vs rises. With 0 it rises in the same cycle as vs.
- R6: hs is high for cfg_hs_high cycles and low for cfg_hs_low cycles, for cfg_hs_cnt high pulses, and then stays low until the next frame. A count of 0 acts as 1, and cfg_hs_cnt = 0 means no hs pulses at all.
- R7: de follows the same rules as hs, using cfg_de_dly, cfg_de_high, cfg_de_low and cfg_de_cnt.
- R8: A new frame start restarts the hs and de sequences from their delays, cutting off any sequence still running.
- R9: The configuration is captured at each frame start and while the block is disabled. A change made in the middle of a frame has no effect until the next frame start.
- R10: Dropping enable in the middle of a frame clears all outputs after the next edge. Raising it again restarts from the vs delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the generator when high |
| cfg_vs_dly | input | 24 | Cycles from enable to the first vs rise |
| cfg_vs_high | input | 24 | vs high length in cycles |
| cfg_vs_low | input | 24 | vs low length in cycles |
| cfg_hs_dly | input | 24 | Cycles from the vs rise to the first hs rise |
| cfg_hs_high | input | 16 | hs high length |
| cfg_hs_low | input | 16 | hs low length |
| cfg_hs_cnt | input | 16 | hs pulses per frame |
| cfg_de_dly | input | 24 | Cycles from the vs rise to the first de rise |
| cfg_de_high | input | 16 | de high length (active width) |
| cfg_de_low | input | 16 | de low length (blanking) |
| cfg_de_cnt | input | 16 | de pulses per frame (active lines) |
| vs | output | 1 | Vertical sync |
| hs | output | 1 | Horizontal sync |
| de | output | 1 | Data enable |
| frame_start | output | 1 | One-cycle marker at each vs rise |

## Verification
Two events can fall in the same cycle. A frame start, which also captures the configuration, can land on a cycle where an hs or de sequence is still busy. A strobe with zero delay also rises on the very edge where vs rises. The first case is provoked by a repeat count far larger than a frame holds and by a delay longer than the frame. The second is provoked by zero delays and by changing the configuration in the middle of a frame. Every output is compared on every cycle against a model built from the requirements. The model treats each frame as a fresh sequence that uses the configuration held at its start.

// File: rtl/stg_pkg.sv
package stg_pkg;

    localparam int unsigned STG_VW = 24;   // vertical / delay counter width
    localparam int unsigned STG_HW = 16;   // horizontal length and repeat width

    typedef struct packed {
        logic [STG_VW-1:0] vs_dly;
        logic [STG_VW-1:0] vs_high;
        logic [STG_VW-1:0] vs_low;
        logic [STG_VW-1:0] hs_dly;
        logic [STG_HW-1:0] hs_high;
        logic [STG_HW-1:0] hs_low;
        logic [STG_HW-1:0] hs_cnt;
        logic [STG_VW-1:0] de_dly;
        logic [STG_HW-1:0] de_high;
        logic [STG_HW-1:0] de_low;
        logic [STG_HW-1:0] de_cnt;
    } stg_cfg_t;

    typedef enum logic [1:0] {
        V_IDLE  = 2'd0,
        V_DELAY = 2'd1,
        V_HIGH  = 2'd2,
        V_LOW   = 2'd3
    } vstate_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_HIGH = 2'd2,
        S_LOW  = 2'd3
    } sstate_e;

endpackage

// File: rtl/stg_cfg_shadow.sv
module stg_cfg_shadow
    import stg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  stg_cfg_t          live,
    output stg_cfg_t          eff,
    output logic [STG_VW-1:0] held_vs_dly
);

    stg_cfg_t held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (capture) begin
            held_q <= live;
        end
    end

    // On a capture cycle the fresh values are what the counters load
    always_comb begin
        eff         = capture ? live : held_q;
        held_vs_dly = held_q.vs_dly;
    end

    // R9: outside capture cycles the shadow copy never moves
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(held_q));

endmodule

// File: rtl/stg_vert_fsm.sv
module stg_vert_fsm
    import stg_pkg::*;
#(
    parameter int unsigned VW = STG_VW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [VW-1:0] dly_len,
    input  logic [VW-1:0] high_len,
    input  logic [VW-1:0] low_len,
    output logic          frame_enter,
    output logic          vs,
    output logic          frame_start
);

    localparam logic [VW-1:0] ONE = VW'(1);

    vstate_e       st_q, st_n;
    logic [VW-1:0] cnt_q, cnt_n;
    logic          fs_q;
    logic [VW-1:0] hi_ld, lo_ld;

    always_comb begin
        hi_ld = (high_len == '0) ? ONE : high_len;
        lo_ld = (low_len  == '0) ? ONE : low_len;
    end

    // next-state
    always_comb begin
        st_n = st_q;
        if (!enable) begin
            st_n = V_IDLE;
        end else begin
            unique case (st_q)
                V_IDLE:  st_n = (dly_len == '0) ? V_HIGH : V_DELAY;
                V_DELAY: if (cnt_q == ONE) st_n = V_HIGH;
                V_HIGH:  if (cnt_q == ONE) st_n = V_LOW;
                V_LOW:   if (cnt_q == ONE) st_n = V_HIGH;
                default: st_n = V_IDLE;
            endcase
        end
        frame_enter = (st_n == V_HIGH) && (st_q != V_HIGH);
    end

    // counter load on entry, down-count otherwise
    always_comb begin
        cnt_n = (cnt_q != '0) ? cnt_q - ONE : cnt_q;
        if (st_n != st_q) begin
            unique case (st_n)
                V_IDLE:  cnt_n = '0;
                V_DELAY: cnt_n = dly_len;
                V_HIGH:  cnt_n = hi_ld;
                V_LOW:   cnt_n = lo_ld;
                default: cnt_n = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= V_IDLE;
            cnt_q <= '0;
            fs_q  <= 1'b0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            fs_q  <= frame_enter;
        end
    end

    always_comb begin
        vs          = (st_q == V_HIGH);
        frame_start = fs_q;
    end

    // R4: the marker only ever shows inside a vs high period
    a_r4_fs_in_vs: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> vs);
    // R4: the marker lasts one cycle
    a_r4_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
    // R3: a running period always has cycles left
    a_r3_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == V_HIGH || st_q == V_LOW) |-> (cnt_q != '0));

endmodule

// File: rtl/stg_strobe_seq.sv
module stg_strobe_seq
    import stg_pkg::*;
#(
    parameter int unsigned DW = STG_VW,
    parameter int unsigned CW = STG_HW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          start,
    input  logic [DW-1:0] dly,
    input  logic [CW-1:0] hi_len,
    input  logic [CW-1:0] lo_len,
    input  logic [CW-1:0] reps,
    output logic          strobe
);

    localparam logic [DW-1:0] D_ONE = DW'(1);
    localparam logic [CW-1:0] C_ONE = CW'(1);

    sstate_e       st_q, st_n;
    logic [DW-1:0] cnt_q, cnt_n;
    logic [CW-1:0] rep_q, rep_n;
    logic [DW-1:0] hi_ld, lo_ld;

    always_comb begin
        hi_ld = (hi_len == '0) ? D_ONE : DW'(hi_len);
        lo_ld = (lo_len == '0) ? D_ONE : DW'(lo_len);
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = (cnt_q != '0) ? cnt_q - D_ONE : cnt_q;
        rep_n = rep_q;
        if (!enable) begin
            st_n  = S_IDLE;
            cnt_n = '0;
            rep_n = '0;
        end else if (start) begin
            // a frame start overrides whatever is running
            rep_n = reps;
            if (reps == '0) begin
                st_n  = S_IDLE;
                cnt_n = '0;
            end else if (dly == '0) begin
                st_n  = S_HIGH;
                cnt_n = hi_ld;
            end else begin
                st_n  = S_WAIT;
                cnt_n = dly;
            end
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    cnt_n = cnt_q;
                end
                S_WAIT: begin
                    if (cnt_q == D_ONE) begin
                        st_n  = S_HIGH;
                        cnt_n = hi_ld;
                    end
                end
                S_HIGH: begin
                    if (cnt_q == D_ONE) begin
                        if (rep_q == C_ONE) begin
                            st_n = S_IDLE;
                        end else begin
                            st_n  = S_LOW;
                            cnt_n = lo_ld;
                            rep_n = rep_q - C_ONE;
                        end
                    end
                end
                S_LOW: begin
                    if (cnt_q == D_ONE) begin
                        st_n  = S_HIGH;
                        cnt_n = hi_ld;
                    end
                end
                default: st_n = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            rep_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            rep_q <= rep_n;
        end
    end

    always_comb strobe = (st_q == S_HIGH);

    // R6: a pulse is only ever driven while the repeat budget is not spent
    a_r6_budget_live: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_HIGH) |-> (rep_q != '0));
    // R8: a start always leaves the sequencer in a defined entry state
    a_r8_restart_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (start && enable) |=> (st_q != S_LOW));

endmodule

// File: rtl/sync_timing_gen.sv
module sync_timing_gen
    import stg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [STG_VW-1:0] cfg_vs_dly,
    input  logic [STG_VW-1:0] cfg_vs_high,
    input  logic [STG_VW-1:0] cfg_vs_low,
    input  logic [STG_VW-1:0] cfg_hs_dly,
    input  logic [STG_HW-1:0] cfg_hs_high,
    input  logic [STG_HW-1:0] cfg_hs_low,
    input  logic [STG_HW-1:0] cfg_hs_cnt,
    input  logic [STG_VW-1:0] cfg_de_dly,
    input  logic [STG_HW-1:0] cfg_de_high,
    input  logic [STG_HW-1:0] cfg_de_low,
    input  logic [STG_HW-1:0] cfg_de_cnt,
    output logic              vs,
    output logic              hs,
    output logic              de,
    output logic              frame_start
);

    stg_cfg_t          live_cfg;
    stg_cfg_t          eff_cfg;
    logic [STG_VW-1:0] held_vs_dly;
    logic              frame_enter;
    logic              capture;

    always_comb begin
        live_cfg.vs_dly  = cfg_vs_dly;
        live_cfg.vs_high = cfg_vs_high;
        live_cfg.vs_low  = cfg_vs_low;
        live_cfg.hs_dly  = cfg_hs_dly;
        live_cfg.hs_high = cfg_hs_high;
        live_cfg.hs_low  = cfg_hs_low;
        live_cfg.hs_cnt  = cfg_hs_cnt;
        live_cfg.de_dly  = cfg_de_dly;
        live_cfg.de_high = cfg_de_high;
        live_cfg.de_low  = cfg_de_low;
        live_cfg.de_cnt  = cfg_de_cnt;
        capture          = !enable || frame_enter;
    end

    stg_cfg_shadow u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .live        (live_cfg),
        .eff         (eff_cfg),
        .held_vs_dly (held_vs_dly)
    );

    stg_vert_fsm #(.VW(STG_VW)) u_vert (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .dly_len     (held_vs_dly),
        .high_len    (eff_cfg.vs_high),
        .low_len     (eff_cfg.vs_low),
        .frame_enter (frame_enter),
        .vs          (vs),
        .frame_start (frame_start)
    );

    stg_strobe_seq #(.DW(STG_VW), .CW(STG_HW)) u_hs_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .start  (frame_enter),
        .dly    (eff_cfg.hs_dly),
        .hi_len (eff_cfg.hs_high),
        .lo_len (eff_cfg.hs_low),
        .reps   (eff_cfg.hs_cnt),
        .strobe (hs)
    );

    stg_strobe_seq #(.DW(STG_VW), .CW(STG_HW)) u_de_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .start  (frame_enter),
        .dly    (eff_cfg.de_dly),
        .hi_len (eff_cfg.de_high),
        .lo_len (eff_cfg.de_low),
        .reps   (eff_cfg.de_cnt),
        .strobe (de)
    );

    // R1 / R10: a low enable silences every output after one edge
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!vs && !hs && !de && !frame_start));
    // R4: every vs rise carries the frame marker
    a_r4_rise_marked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs) |-> frame_start);

endmodule

// File: tb/sync_timing_gen_tb_top.sv
module sync_timing_gen_tb_top;

    typedef struct packed {
        int vd; int vh; int vl;
        int hd; int hh; int hl; int hc;
        int dd; int dh; int dl; int dc;
        int cyc;
    } row_t;

    localparam int NROWS = 5;
    localparam row_t ROWS [NROWS] = '{
        // R2 delayed start, R5 delayed hs, R7 de
        '{3, 6, 34, 2, 2, 3, 8, 7, 4, 2, 4, 130},
        // R5 zero delays: hs and de rise with vs
        '{0, 1, 19, 0, 1, 1, 10, 0, 3, 1, 2, 70},
        // R3 R6 zero lengths act as one, de count zero
        '{2, 0, 9, 1, 0, 0, 3, 2, 5, 5, 0, 50},
        // R8 hs cut by the next frame, de delay beyond frame
        '{1, 2, 18, 5, 4, 4, 100, 25, 2, 2, 3, 70},
        // R7 scaled raster: line 14, frame 7 lines
        '{2, 14, 84, 0, 1, 13, 7, 46, 8, 6, 3, 210}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic [23:0] cfg_vs_dly, cfg_vs_high, cfg_vs_low, cfg_hs_dly, cfg_de_dly;
    logic [15:0] cfg_hs_high, cfg_hs_low, cfg_hs_cnt;
    logic [15:0] cfg_de_high, cfg_de_low, cfg_de_cnt;
    logic        vs, hs, de, frame_start;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sync_timing_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .cfg_vs_dly  (cfg_vs_dly),
        .cfg_vs_high (cfg_vs_high),
        .cfg_vs_low  (cfg_vs_low),
        .cfg_hs_dly  (cfg_hs_dly),
        .cfg_hs_high (cfg_hs_high),
        .cfg_hs_low  (cfg_hs_low),
        .cfg_hs_cnt  (cfg_hs_cnt),
        .cfg_de_dly  (cfg_de_dly),
        .cfg_de_high (cfg_de_high),
        .cfg_de_low  (cfg_de_low),
        .cfg_de_cnt  (cfg_de_cnt),
        .vs          (vs),
        .hs          (hs),
        .de          (de),
        .frame_start (frame_start)
    );

    function automatic int s1(int x);
        return (x == 0) ? 1 : x;
    endfunction

    function automatic logic pulse_at(int f, int d, int h, int l, int c);
        int u;
        int per;
        if (f < d) return 1'b0;
        u   = f - d;
        per = s1(h) + s1(l);
        if ((u / per) >= c) return 1'b0;
        return (u % per) < s1(h);
    endfunction

    // expected {vs, hs, de, frame_start}, n edges after the enabling edge
    function automatic logic [3:0] model(row_t r, int n);
        int t;
        int f;
        t = n - r.vd;
        if (t < 0) return 4'b0000;
        f = t % (s1(r.vh) + s1(r.vl));
        return {f < s1(r.vh),
                pulse_at(f, r.hd, r.hh, r.hl, r.hc),
                pulse_at(f, r.dd, r.dh, r.dl, r.dc),
                f == 0};
    endfunction

    function automatic string row_tag(int i);
        case (i)
            0: return "R2";
            1: return "R5";
            2: return "R3";
            3: return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
        end
    endtask

    task automatic chk_quiet(string tag);
        chk({tag, " vs low"}, vs, 1'b0);
        chk({tag, " hs low"}, hs, 1'b0);
        chk({tag, " de low"}, de, 1'b0);
        chk({tag, " frame_start low"}, frame_start, 1'b0);
    endtask

    task automatic cmp(string ctx, row_t r, int n);
        logic [3:0] e;
        e = model(r, n);
        chk({ctx, " R3 vs"}, vs, e[3]);
        chk({ctx, " R6 hs"}, hs, e[2]);
        chk({ctx, " R7 de"}, de, e[1]);
        chk({ctx, " R4 frame_start"}, frame_start, e[0]);
    endtask

    task automatic apply(row_t r);
        cfg_vs_dly  = 24'(r.vd);
        cfg_vs_high = 24'(r.vh);
        cfg_vs_low  = 24'(r.vl);
        cfg_hs_dly  = 24'(r.hd);
        cfg_hs_high = 16'(r.hh);
        cfg_hs_low  = 16'(r.hl);
        cfg_hs_cnt  = 16'(r.hc);
        cfg_de_dly  = 24'(r.dd);
        cfg_de_high = 16'(r.dh);
        cfg_de_low  = 16'(r.dl);
        cfg_de_cnt  = 16'(r.dc);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        row_t a;
        row_t b;
        row_t c;
        rst_n  = 1'b0;
        enable = 1'b0;
        apply(ROWS[0]);
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk_quiet("R1 reset");
        end
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            enable = 1'b0;
            apply(ROWS[i]);
            repeat (2) begin
                @(negedge clk);
                chk_quiet("R1 disabled");
            end
            enable = 1'b1;
            for (int n = 0; n < ROWS[i].cyc; n++) begin
                @(negedge clk);
                cmp(row_tag(i), ROWS[i], n);
            end
        end

        // R9: mid-frame change waits for the next frame start
        @(negedge clk);
        enable = 1'b0;
        a = '{0, 6, 34, 2, 2, 3, 8, 7, 4, 2, 4, 0};
        b = a;
        b.vh = 10;
        b.hc = 2;
        apply(a);
        repeat (2) @(negedge clk);
        enable = 1'b1;
        for (int n = 0; n < 128; n++) begin
            @(negedge clk);
            if (n < 40) cmp("R9 old", a, n);
            else        cmp("R9 new", b, n - 40);
            if (n == 10) apply(b);
        end

        // R10: disable mid-frame, then re-enable with the delay again
        @(negedge clk);
        enable = 1'b0;
        c = '{4, 3, 7, 1, 1, 2, 3, 0, 2, 1, 2, 0};
        apply(c);
        repeat (2) @(negedge clk);
        enable = 1'b1;
        for (int n = 0; n < 15; n++) begin
            @(negedge clk);
            cmp("R10 first", c, n);
        end
        enable = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk_quiet("R10 dropped");
        end
        enable = 1'b1;
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            cmp("R10 again", c, n);
        end

        // R1: asynchronous reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_quiet("R1 async reset");
        @(negedge clk);
        chk_quiet("R1 held reset");
        enable = 1'b0;
        rst_n  = 1'b1;
        @(negedge clk);
        chk_quiet("R1 after reset");

        done = 1'b1;
        finish_run();
    end

endmodule